// File: doc/BRIEF.md
# 8-bit ALU with status flags

This is the combinational arithmetic and logic stage of a small 8-bit RISC core. Each cycle it takes two operands, an operation code and the current status byte. It returns the operation result, the next status byte and a write-back strobe that tells the register file whether the result should be stored. Compare operations set the flags only and keep the strobe low.

Each group of operations updates its own fixed set of flags and passes every other flag through unchanged. Subtract-with-carry and compare-with-carry chain the zero flag across bytes, so a multi-byte value can be tested for zero one byte at a time. The signed-test flag is always re-derived from the new negative and overflow flags.

Top module: `alu8_core`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0, I, T, H, S, V, N, Z, C. No operation changes I (bit 7) or T (bit 6).
- R2: The opcode encoding is ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ASR=15, ROL=16, ROR=17, SWAP=18. For ADD (a+b) and ADC (a+b+C), C is the carry out of bit 7, H is the carry out of bit 3, and V flags a signed overflow. Z is set for a zero result and N is result bit 7.
- R3: SUB (a-b) and SBC (a-b-C) set C to the borrow out of bit 7 and H to the borrow out of bit 3. V flags a signed overflow, and N is result bit 7. SUB sets Z for a zero result.
- R4: For SBC and CPC, Z is set only when the result is zero and the incoming Z is already 1. A nonzero byte clears Z.
- R5: CP and CPC set the flags exactly as SUB and SBC do, and hold wr_en at 0. Every other defined opcode except those two drives wr_en to 1.
- R6: AND, OR and XOR update Z and N, clear V, and leave C and H unchanged.
- R7: INC and DEC update Z and N, and leave C and H unchanged. V is set only when INC produces 0x80 or DEC produces 0x7F.
- R8: COM returns 0xFF minus a and sets C=1 and V=0. NEG returns 0x00 minus a, with C=1 exactly when a is nonzero, V=1 exactly when the result is 0x80, and H set on a borrow out of bit 3. COM leaves H unchanged.
- R9: LSL shifts in 0 at bit 0, LSR shifts in 0 at bit 7, and ASR keeps bit 7. Each puts the bit shifted out into C and sets V = N xor C. H is left unchanged.
- R10: ROL shifts the old C in at bit 0 and bit 7 out into C. ROR shifts the old C in at bit 7 and bit 0 out into C. Their Z, N and V follow R9.
- R11: SWAP exchanges the two nibbles of a and changes no flag.
- R12: For every opcode that updates N or V, S equals the new N xor the new V.
- R13: An opcode of 19 or more returns a unchanged, changes no flag, and holds wr_en at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand (destination register value) |
| b | input | 8 | Second operand (source register or constant) |
| op | input | 5 | Operation code, encoding in R2 |
| sreg_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| sreg_out | output | 8 | Next status byte |
| wr_en | output | 1 | Result should be written back |

## Verification
The block has no register, so result, sreg_out and wr_en are all due in the same cycle that the operands, opcode and status byte are applied. The bench drives new inputs on the falling clock edge and samples the outputs two nanoseconds later, well before the next rising edge. Every sample is compared against a bench model that computes the flags from per-bit carry equations, not from wide sums. Random operands and status bytes go through every opcode. Directed vectors then hit the 0x7F/0x80 overflow edge, the 0x0F/0x10 nibble edge, zero chaining and an unused opcode.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    // status byte bit positions (the core's branch logic decodes these)
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;

    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic           zin,
    output logic [W-1:0]   res,
    output flag_t          fl,
    output flag_t          upd
);
    localparam int HALF = W / 2;

    logic [W-1:0]  x, y;
    logic          ci, sub, chain;
    logic [W:0]    wide;
    logic [HALF:0] low;

    always_comb begin
        x = a; y = b; ci = 1'b0; sub = 1'b0; chain = 1'b0;
        upd = '{h: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
        unique case (op)
            OP_ADD:        ;
            OP_ADC:        ci = cin;
            OP_SUB, OP_CP: sub = 1'b1;
            OP_SBC, OP_CPC: begin sub = 1'b1; ci = cin; chain = 1'b1; end
            OP_NEG:        begin x = '0; y = a; sub = 1'b1; end
            default:       upd = '0;
        endcase
    end

    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
            low  = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, ci};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
            low  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};
        end
        res  = wide[W-1:0];
        fl.c = wide[W];
        fl.h = low[HALF];
        fl.n = res[W-1];
        fl.z = (res == '0) && (!chain || zin);
        if (sub)
            fl.v = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
        else
            fl.v = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
    end

    // zero chaining: a nonzero byte never leaves Z set (R4)
    always_comb begin
        if (chain && res != '0)
            p_chain_clears_z_r4: assert (!fl.z);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output flag_t          fl,
    output flag_t          upd
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = ~MIN_NEG;

    always_comb begin
        res  = a;
        fl.v = 1'b0;
        fl.c = 1'b0;
        fl.h = 1'b0;
        upd  = '{h: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_COM: begin res = ~a; fl.c = 1'b1; upd.c = 1'b1; end
            OP_INC: begin res = a + 1'b1; fl.v = (res == MIN_NEG); end
            OP_DEC: begin res = a - 1'b1; fl.v = (res == MAX_POS); end
            default: upd = '0;
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output flag_t          fl,
    output flag_t          upd
);
    localparam int HALF = W / 2;

    always_comb begin
        res  = a;
        fl.c = 1'b0;
        fl.h = 1'b0;
        upd  = '{h: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
        unique case (op)
            OP_LSL:  begin res = {a[W-2:0], 1'b0};   fl.c = a[W-1]; end
            OP_LSR:  begin res = {1'b0, a[W-1:1]};   fl.c = a[0];   end
            OP_ASR:  begin res = {a[W-1], a[W-1:1]}; fl.c = a[0];   end
            OP_ROL:  begin res = {a[W-2:0], cin};    fl.c = a[W-1]; end
            OP_ROR:  begin res = {cin, a[W-1:1]};    fl.c = a[0];   end
            OP_SWAP: begin res = {a[HALF-1:0], a[W-1:HALF]}; upd = '0; end
            default: upd = '0;
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
        fl.v = fl.n ^ fl.c;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [4:0]   op,
    input  logic [7:0]   sreg_in,
    output logic [W-1:0] result,
    output logic [7:0]   sreg_out,
    output logic         wr_en
);
    alu_op_e opc;
    assign opc = alu_op_e'(op);

    typedef enum logic [1:0] {CL_ARITH, CL_LOGIC, CL_SHIFT, CL_NONE} op_class_e;
    op_class_e cls;

    logic [W-1:0] ar_res, lg_res, sh_res;
    flag_t        ar_fl, lg_fl, sh_fl;
    flag_t        ar_upd, lg_upd, sh_upd;
    flag_t        sel_fl, sel_upd;

    alu8_arith #(.W(W)) u_arith (
        .op(opc), .a(a), .b(b), .cin(sreg_in[FB_C]), .zin(sreg_in[FB_Z]),
        .res(ar_res), .fl(ar_fl), .upd(ar_upd)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(opc), .a(a), .b(b),
        .res(lg_res), .fl(lg_fl), .upd(lg_upd)
    );

    alu8_shift #(.W(W)) u_shift (
        .op(opc), .a(a), .cin(sreg_in[FB_C]),
        .res(sh_res), .fl(sh_fl), .upd(sh_upd)
    );

    always_comb begin
        unique case (opc)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_CP, OP_CPC, OP_NEG:                  cls = CL_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM,
            OP_INC, OP_DEC:                         cls = CL_LOGIC;
            OP_LSL, OP_LSR, OP_ASR, OP_ROL,
            OP_ROR, OP_SWAP:                        cls = CL_SHIFT;
            default:                                cls = CL_NONE;
        endcase
    end

    always_comb begin
        unique case (cls)
            CL_ARITH: begin result = ar_res; sel_fl = ar_fl; sel_upd = ar_upd; end
            CL_LOGIC: begin result = lg_res; sel_fl = lg_fl; sel_upd = lg_upd; end
            CL_SHIFT: begin result = sh_res; sel_fl = sh_fl; sel_upd = sh_upd; end
            default:  begin result = a;      sel_fl = '0;    sel_upd = '0;     end
        endcase
        wr_en = (cls != CL_NONE) && (opc != OP_CP) && (opc != OP_CPC);
    end

    always_comb begin
        sreg_out = sreg_in;
        if (sel_upd.c) sreg_out[FB_C] = sel_fl.c;
        if (sel_upd.z) sreg_out[FB_Z] = sel_fl.z;
        if (sel_upd.n) sreg_out[FB_N] = sel_fl.n;
        if (sel_upd.v) sreg_out[FB_V] = sel_fl.v;
        if (sel_upd.h) sreg_out[FB_H] = sel_fl.h;
        if (sel_upd.n || sel_upd.v)
            sreg_out[FB_S] = sreg_out[FB_N] ^ sreg_out[FB_V];
    end

    // checks on the merged status byte
    always_comb begin
        p_it_held_r1: assert (sreg_out[7:6] == sreg_in[7:6]);
        if (opc == OP_CP || opc == OP_CPC)
            p_compare_no_wb_r5: assert (!wr_en);
        if (opc == OP_AND || opc == OP_OR || opc == OP_XOR ||
            opc == OP_INC || opc == OP_DEC)
            p_logic_keeps_ch_r6: assert (sreg_out[FB_C] == sreg_in[FB_C] &&
                                         sreg_out[FB_H] == sreg_in[FB_H]);
        if (opc == OP_SWAP)
            p_swap_flags_kept_r11: assert (sreg_out == sreg_in);
        if (cls != CL_NONE && opc != OP_SWAP)
            p_sign_test_r12: assert (sreg_out[FB_S] == (sreg_out[FB_N] ^ sreg_out[FB_V]));
        if (cls == CL_NONE)
            p_unused_inert_r13: assert (result == a && sreg_out == sreg_in && !wr_en);
    end
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] a, b, sreg_in;
    logic [4:0] op;
    logic [7:0] result, sreg_out;
    logic       wr_en;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut (
        .a(a), .b(b), .op(op), .sreg_in(sreg_in),
        .result(result), .sreg_out(sreg_out), .wr_en(wr_en)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1:            return "R2";
            2:               return "R3";
            3:               return "R4";
            4, 5:            return "R5";
            6, 7, 8:         return "R6";
            11, 12:          return "R7";
            9, 10:           return "R8";
            13, 14, 15:      return "R9";
            16, 17:          return "R10";
            18:              return "R11";
            default:         return "R13";
        endcase
    endfunction

    // expected {wr, result, status} from per-bit flag equations
    function automatic logic [16:0] model(input int o, input logic [7:0] x,
                                          input logic [7:0] y, input logic [7:0] s);
        logic [7:0] r, ns;
        logic wr, c, h, v, n, z, upn;
        ns = s; r = x; wr = 1'b1; upn = 1'b1;
        c = s[0]; h = s[5]; v = s[3];
        case (o)
            0, 1: begin
                r = x + y + ((o == 1) ? {7'd0, s[0]} : 8'd0);
                h = (x[3] & y[3]) | (y[3] & ~r[3]) | (~r[3] & x[3]);
                v = (x[7] & y[7] & ~r[7]) | (~x[7] & ~y[7] & r[7]);
                c = (x[7] & y[7]) | (y[7] & ~r[7]) | (~r[7] & x[7]);
            end
            2, 3, 4, 5: begin
                r = x - y - ((o == 3 || o == 5) ? {7'd0, s[0]} : 8'd0);
                h = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
                v = (x[7] & ~y[7] & ~r[7]) | (~x[7] & y[7] & r[7]);
                c = (~x[7] & y[7]) | (y[7] & r[7]) | (r[7] & ~x[7]);
                wr = !(o == 4 || o == 5);
            end
            6:  begin r = x & y; v = 1'b0; end
            7:  begin r = x | y; v = 1'b0; end
            8:  begin r = x ^ y; v = 1'b0; end
            9:  begin r = 8'hFF - x; v = 1'b0; c = 1'b1; end
            10: begin r = 8'h00 - x; h = r[3] | x[3]; v = (r == 8'h80); c = (r != 0); end
            11: begin r = x + 8'd1; v = (x == 8'h7F); end
            12: begin r = x - 8'd1; v = (x == 8'h80); end
            13: begin r = x << 1; c = x[7]; end
            14: begin r = x >> 1; c = x[0]; end
            15: begin r = {x[7], x[7:1]}; c = x[0]; end
            16: begin r = {x[6:0], s[0]}; c = x[7]; end
            17: begin r = {s[0], x[7:1]}; c = x[0]; end
            18: begin r = {x[3:0], x[7:4]}; upn = 1'b0; end
            default: begin wr = 1'b0; upn = 1'b0; end
        endcase
        n = r[7];
        if (o >= 13 && o <= 17) v = n ^ c;
        z = (r == 0);
        if (o == 3 || o == 5) z = z & s[1];
        if (upn) begin
            ns[0] = c; ns[1] = z; ns[2] = n; ns[3] = v; ns[5] = h;
            ns[4] = n ^ v;
        end
        return {wr, r, ns};
    endfunction

    task automatic apply(input int o, input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] s, input string tag);
        logic [16:0] exp;
        @(negedge clk);
        op = o[4:0]; a = x; b = y; sreg_in = s;
        #2;
        exp = model(o, x, y, s);
        n_tests++;
        if ({wr_en, result, sreg_out} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h s=%h : got wr=%b res=%h sreg=%h, exp wr=%b res=%h sreg=%h",
                     tag, o, x, y, s, wr_en, result, sreg_out, exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        op = '0; a = '0; b = '0; sreg_in = '0;

        // initial state: all-zero inputs give ADD 0+0 -> Z only (R2)
        apply(0, 8'h00, 8'h00, 8'h00, "R2");

        // R1: I and T untouched by an operation that rewrites every other flag
        apply(0, 8'h7F, 8'h01, 8'hC0, "R1");
        check_bit("R1 I", sreg_out[7], 1'b1);
        check_bit("R1 T", sreg_out[6], 1'b1);

        // R2 / R3 overflow and nibble edges
        apply(0, 8'h7F, 8'h01, 8'h00, "R2");
        apply(0, 8'h80, 8'h80, 8'h00, "R2");
        apply(0, 8'h0F, 8'h01, 8'h00, "R2");
        apply(1, 8'hFF, 8'h00, 8'h01, "R2");
        apply(2, 8'h10, 8'h01, 8'h00, "R3");
        apply(2, 8'h80, 8'h01, 8'h00, "R3");
        apply(2, 8'h00, 8'h01, 8'h00, "R3");

        // R4: zero chaining across bytes
        apply(3, 8'h05, 8'h05, 8'h02, "R4");
        apply(3, 8'h05, 8'h05, 8'h00, "R4");
        apply(5, 8'h05, 8'h04, 8'h03, "R4");
        apply(5, 8'h00, 8'h00, 8'h02, "R4");

        // R5: compare writes nothing back
        apply(4, 8'h33, 8'h33, 8'h00, "R5");
        check_bit("R5 wr", wr_en, 1'b0);

        // R6 / R7 / R8 directed
        apply(6, 8'hF0, 8'h0F, 8'h21, "R6");
        apply(11, 8'h7F, 8'h00, 8'h21, "R7");
        apply(12, 8'h80, 8'h00, 8'h00, "R7");
        apply(11, 8'hFF, 8'h00, 8'h00, "R7");
        apply(9, 8'h00, 8'h00, 8'h20, "R8");
        apply(10, 8'h80, 8'h00, 8'h00, "R8");
        apply(10, 8'h00, 8'h00, 8'h3F, "R8");
        apply(10, 8'h10, 8'h00, 8'h00, "R8");

        // R9 / R10 / R11 directed
        apply(15, 8'h81, 8'h00, 8'h00, "R9");
        apply(14, 8'h01, 8'h00, 8'h00, "R9");
        apply(16, 8'h80, 8'h00, 8'h01, "R10");
        apply(17, 8'h01, 8'h00, 8'h01, "R10");
        apply(18, 8'hA5, 8'h00, 8'h3F, "R11");

        // R13: unused opcodes are inert
        apply(19, 8'h5A, 8'h11, 8'h2B, "R13");
        apply(31, 8'hC3, 8'h11, 8'h14, "R13");

        // random sweep of every opcode
        for (int o = 0; o < 19; o++) begin
            for (int k = 0; k < 40; k++) begin
                apply(o, 8'($urandom), 8'($urandom), 8'($urandom), tag_of(o));
                // R12: signed test follows N xor V
                if (o != 18)
                    check_bit("R12", sreg_out[4], sreg_out[2] ^ sreg_out[3]);
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule